// File: doc/BRIEF.md
# Serial-Bus Save Memory and Clock Responder

This block sits behind the bit-level receiver and transmitter of a single-wire controller bus. A complete command frame comes in as a byte array with a length, a one-cycle valid pulse and a flag that says whether the closing stop bit was seen. The block decodes the command and builds the response frame. That response can be a status word, an 8-byte block read from backing memory, an acknowledgement after writing an 8-byte block, or fixed clock data. It then strobes the transmitter once the transmitter is free. Each finished frame ends with a one-cycle re-arm pulse back to the receiver.

The save memory is reached through a word-addressed synchronous port. Read data returns one cycle after the read request. Each 8-byte block occupies two consecutive 32-bit words starting at `save_base + 2*index`. Byte `4k+n` of a block sits in bits `[8n+7:8n]` of word `k`. Frame byte `i` is carried in bits `[8i+7:8i]` of both the input and the output byte arrays.

Top module: `sbus_save_responder`

## Requirements
- R1: After reset, `tx_start`, `rx_rearm`, `mem_rd` and `mem_wr` are low and `tx_len` is 0.
- R2: A frame whose stop bit was not seen, or whose length is 0, gets no response and no memory access. `rx_rearm` pulses in the first cycle after the valid pulse.
- R3: Every accepted frame produces exactly one one-cycle `rx_rearm` pulse. When a response is sent, `tx_start` pulses in that same cycle, exactly once, and `tx_len` is 1, 3, 8 or 9.
- R4: Command byte 0x00 returns 3 bytes: 0x00, then 0x80 when `eeprom_mode` is 2'b01 or 0xC0 when it is 2'b10, then 0x00.
- R5: Commands 0x00, 0x04 and 0x05 are answered only when `eeprom_mode` is 2'b01 or 2'b10. In the other modes they produce only a re-arm, with no start and no memory access.
- R6: Command 0x04 with block index in byte 1 reads words `save_base+2*idx` and `+1`. It returns 8 bytes: the four bytes of the first word, lowest byte first, followed by the four bytes of the second word.
- R7: Command 0x05 writes frame bytes 2..5 into word `save_base+2*idx` and bytes 6..9 into the next word, with the lowest-numbered byte in bits [7:0]. It then returns the single byte 0x00.
- R8: Command 0x06 returns 3 bytes: 0x00, 0x10, 0x00, in every `eeprom_mode`.
- R9: Command 0x07 returns 9 bytes. For block index 0 these are 0x03 followed by eight 0x00. For any other index they are 00 00 92 06 01 09 21 01 00.
- R10: Command 0x08 returns the single byte 0x00.
- R11: Any other command byte produces only a re-arm and never a start.
- R12: While `tx_busy` is high, no `tx_start` and no re-arm is issued. The pending response starts in the cycle after `tx_busy` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle pulse: a received frame is ready |
| rx_stop_ok | input | 1 | Stop bit of the frame was seen |
| rx_len | input | 4 | Number of valid received bytes |
| rx_bytes | input | 80 | Received bytes, byte i at [8i+7:8i] |
| eeprom_mode | input | 2 | 2'b01 small EEPROM, 2'b10 large EEPROM, others no EEPROM |
| save_base | input | 16 | Word address of block 0 in backing memory |
| tx_busy | input | 1 | Transmitter still sending |
| tx_start | output | 1 | One-cycle strobe to start the response |
| tx_len | output | 4 | Response length in bytes |
| tx_bytes | output | 72 | Response bytes, byte i at [8i+7:8i], unused bytes zero |
| rx_rearm | output | 1 | One-cycle pulse re-arming the receiver |
| mem_rd | output | 1 | Word read request |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |

## Verification
A sequencer stuck outside idle shows at the ports as a missing `rx_rearm` within a few cycles of a frame. A wrong decode shows at the strobe, either as a response length outside the allowed set or as a start where a silent re-arm was due. A read pipeline that is off by one cycle puts the wrong word into one half of the 8-byte response, or its neighbour's word. A write address error surfaces on the read that follows. The holdoff path is exposed by any start that lands while the transmitter reports busy, and the bench sees it within one cycle.

// File: rtl/sbus_save_responder.sv
module sbus_save_responder #(
  parameter int AW  = 16,
  parameter int RXN = 10,
  parameter int TXN = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic               rx_stop_ok,
  input  logic [$clog2(RXN+1)-1:0] rx_len,
  input  logic [8*RXN-1:0]   rx_bytes,
  input  logic [1:0]         eeprom_mode,
  input  logic [AW-1:0]      save_base,
  input  logic               tx_busy,
  output logic               tx_start,
  output logic [$clog2(TXN+1)-1:0] tx_len,
  output logic [8*TXN-1:0]   tx_bytes,
  output logic               rx_rearm,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [AW-1:0]      mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata
);
  localparam int LW = $clog2(TXN+1);
  localparam int TB = 8*TXN;
  localparam logic [7:0] C_EE_STAT  = 8'h00;
  localparam logic [7:0] C_EE_RD    = 8'h04;
  localparam logic [7:0] C_EE_WR    = 8'h05;
  localparam logic [7:0] C_RTC_STAT = 8'h06;
  localparam logic [7:0] C_RTC_RD   = 8'h07;
  localparam logic [7:0] C_RTC_WR   = 8'h08;

  typedef enum logic [2:0] {S_IDLE, S_RA, S_RB, S_RC, S_WB, S_TX} st_t;
  typedef enum logic [1:0] {K_NONE, K_IMM, K_RD, K_WR} kind_t;

  st_t   st;
  kind_t kind;
  logic [LW-1:0] imm_len;
  logic [TB-1:0] imm_bytes;

  wire [7:0]    cmd   = rx_bytes[7:0];
  wire [7:0]    idx   = rx_bytes[15:8];
  wire          ee_on = (eeprom_mode == 2'b01) || (eeprom_mode == 2'b10);
  wire [AW-1:0] blk   = save_base + AW'({idx, 1'b0});
  wire          drop  = !rx_stop_ok || (rx_len == '0) || (kind == K_NONE);

  always_comb begin
    kind      = K_NONE;
    imm_len   = '0;
    imm_bytes = '0;
    case (cmd)
      C_EE_STAT: if (ee_on) begin
        kind            = K_IMM;
        imm_len         = LW'(3);
        imm_bytes[15:8] = (eeprom_mode == 2'b01) ? 8'h80 : 8'hC0;
      end
      C_EE_RD: if (ee_on) kind = K_RD;
      C_EE_WR: if (ee_on) kind = K_WR;
      C_RTC_STAT: begin
        kind            = K_IMM;
        imm_len         = LW'(3);
        imm_bytes[15:8] = 8'h10;
      end
      C_RTC_RD: begin
        kind    = K_IMM;
        imm_len = LW'(9);
        if (idx == 8'd0) imm_bytes[7:0] = 8'h03;
        else imm_bytes = TB'(72'h00_01_21_09_01_06_92_00_00);
      end
      C_RTC_WR: begin
        kind    = K_IMM;
        imm_len = LW'(1);
      end
      default: kind = K_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tx_start  <= 1'b0;
      rx_rearm  <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_len    <= '0;
      tx_bytes  <= '0;
    end else begin
      tx_start <= 1'b0;
      rx_rearm <= 1'b0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      case (st)
        S_IDLE: if (rx_valid) begin
          if (drop) rx_rearm <= 1'b1;
          else begin
            case (kind)
              K_IMM: begin
                tx_len   <= imm_len;
                tx_bytes <= imm_bytes;
                st       <= S_TX;
              end
              K_RD: begin
                mem_rd   <= 1'b1;
                mem_addr <= blk;
                st       <= S_RA;
              end
              default: begin
                mem_wr    <= 1'b1;
                mem_addr  <= blk;
                mem_wdata <= rx_bytes[16 +: 32];
                st        <= S_WB;
              end
            endcase
          end
        end
        S_RA: begin
          mem_rd   <= 1'b1;
          mem_addr <= mem_addr + 1'b1;
          st       <= S_RB;
        end
        S_RB: begin
          tx_bytes[31:0] <= mem_rdata;
          st             <= S_RC;
        end
        S_RC: begin
          tx_bytes[63:32]    <= mem_rdata;
          tx_bytes[TB-1:64]  <= '0;
          tx_len             <= LW'(8);
          st                 <= S_TX;
        end
        S_WB: begin
          mem_wr    <= 1'b1;
          mem_addr  <= mem_addr + 1'b1;
          mem_wdata <= rx_bytes[48 +: 32];
          tx_len    <= LW'(1);
          tx_bytes  <= '0;
          st        <= S_TX;
        end
        S_TX: if (!tx_busy) begin
          tx_start <= 1'b1;
          rx_rearm <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbus_save_responder_chk.sv
module sbus_save_responder_chk #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_stop_ok,
  input logic          tx_busy,
  input logic          tx_start,
  input logic [LW-1:0] tx_len,
  input logic          rx_rearm,
  input logic          mem_rd,
  input logic          mem_wr
);
  p_start_with_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> rx_rearm);
  p_rearm_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rearm |=> !rx_rearm);
  p_len_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_len == LW'(1) || tx_len == LW'(3) || tx_len == LW'(8) || tx_len == LW'(9)));
  p_holdoff_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> !$past(tx_busy));
  p_stopless_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_stop_ok) |=> (rx_rearm && !tx_start && !mem_rd && !mem_wr));
  p_mem_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

bind sbus_save_responder sbus_save_responder_chk #(.LW(LW)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_stop_ok(rx_stop_ok),
  .tx_busy(tx_busy), .tx_start(tx_start), .tx_len(tx_len),
  .rx_rearm(rx_rearm), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/test_sbus_save_responder.sv
`timescale 1ns/1ps
module test_sbus_save_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_stop_ok = 1'b0;
  logic [3:0]  rx_len = '0;
  logic [79:0] rx_bytes = '0;
  logic [1:0]  eeprom_mode = 2'b00;
  logic [15:0] save_base = 16'd16;
  logic        tx_busy = 1'b0;
  logic        tx_start, rx_rearm, mem_rd, mem_wr;
  logic [3:0]  tx_len;
  logic [71:0] tx_bytes;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  sbus_save_responder i_sbus_save_responder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_stop_ok(rx_stop_ok),
    .rx_len(rx_len), .rx_bytes(rx_bytes), .eeprom_mode(eeprom_mode),
    .save_base(save_base), .tx_busy(tx_busy), .tx_start(tx_start),
    .tx_len(tx_len), .tx_bytes(tx_bytes), .rx_rearm(rx_rearm),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [0:1023];
  function automatic logic [31:0] pat(input int i);
    return {8'(i) ^ 8'h5A, 8'(i), 8'hC3, 8'(i + 1)};
  endfunction
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
  end

  int checks = 0, errors = 0;
  int nstart, nrd, nwr, rearm_at, seen;
  logic [3:0]  cap_len;
  logic [71:0] cap_bytes;

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic [7:0] ix, input bit stop,
                       input logic [3:0] len, input logic [63:0] pay);
    @(negedge clk);
    rx_valid = 1'b1; rx_stop_ok = stop; rx_len = len; rx_bytes = {pay, ix, c};
    @(negedge clk);
    rx_valid = 1'b0;
    nstart = 0; nrd = 0; nwr = 0; rearm_at = -1; seen = 0;
    cap_len = '0; cap_bytes = '0;
  endtask

  task automatic observe(input int maxc);
    for (int k = 0; k < maxc; k++) begin
      if (mem_rd) nrd++;
      if (mem_wr) nwr++;
      if (tx_start) begin nstart++; cap_len = tx_len; cap_bytes = tx_bytes; end
      if (rx_rearm) begin rearm_at = seen; seen++; @(negedge clk); break; end
      seen++;
      @(negedge clk);
    end
  endtask

  function automatic string req_of(input logic [7:0] c, input logic [3:0] l);
    if (l == 0) return (c == 8'h00 || c == 8'h04 || c == 8'h05) ? "R5" : "R11";
    case (c)
      8'h00: return "R4";
      8'h06: return "R8";
      8'h07: return "R9";
      default: return "R10";
    endcase
  endfunction

  localparam int NV = 12;
  localparam logic [93:0] VEC [NV] = '{
    {8'h00, 8'h00, 2'b01, 4'd3, 72'h00_80_00},
    {8'h00, 8'h00, 2'b10, 4'd3, 72'h00_C0_00},
    {8'h06, 8'h00, 2'b00, 4'd3, 72'h00_10_00},
    {8'h06, 8'h00, 2'b10, 4'd3, 72'h00_10_00},
    {8'h07, 8'h00, 2'b00, 4'd9, 72'h03},
    {8'h07, 8'h07, 2'b00, 4'd9, 72'h00_01_21_09_01_06_92_00_00},
    {8'h07, 8'h01, 2'b01, 4'd9, 72'h00_01_21_09_01_06_92_00_00},
    {8'h08, 8'h00, 2'b11, 4'd1, 72'h00},
    {8'h00, 8'h00, 2'b00, 4'd0, 72'h00},
    {8'h00, 8'h00, 2'b11, 4'd0, 72'h00},
    {8'h01, 8'h00, 2'b01, 4'd0, 72'h00},
    {8'hFF, 8'h02, 2'b10, 4'd0, 72'h00}
  };

  bit done = 1'b0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %h expected %h", 72'd0, 72'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] wpay;
    logic [71:0] exp;
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_start && !rx_rearm && !mem_rd && !mem_wr && tx_len == 0, "R1",
        {tx_start, rx_rearm, mem_rd, mem_wr, tx_len}, 72'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      eeprom_mode = VEC[v][77:76];
      issue(VEC[v][93:86], VEC[v][85:78], 1'b1, 4'd3, 64'd0);
      observe(20);
      chk(rearm_at >= 0, "R3", 72'(rearm_at), 72'd0);
      chk(nstart == (VEC[v][75:72] != 0 ? 1 : 0) && nrd == 0 && nwr == 0,
          req_of(VEC[v][93:86], VEC[v][75:72]), 72'(nstart), 72'(VEC[v][75:72] != 0));
      if (VEC[v][75:72] != 0)
        chk(cap_len == VEC[v][75:72] && cap_bytes == VEC[v][71:0],
            req_of(VEC[v][93:86], VEC[v][75:72]), cap_bytes, VEC[v][71:0]);
    end

    // R2 stop bit missing
    eeprom_mode = 2'b01;
    issue(8'h06, 8'h00, 1'b0, 4'd3, 64'd0);
    observe(20);
    chk(rearm_at == 0 && nstart == 0 && nrd == 0, "R2", 72'(rearm_at), 72'd0);
    // R2 zero-length frame
    issue(8'h04, 8'h01, 1'b1, 4'd0, 64'd0);
    observe(20);
    chk(rearm_at == 0 && nstart == 0 && nrd == 0, "R2", 72'(nstart), 72'd0);

    // R6 read block 3
    issue(8'h04, 8'h03, 1'b1, 4'd2, 64'd0);
    observe(20);
    exp = {8'h00, pat(16 + 7), pat(16 + 6)};
    chk(nstart == 1 && cap_len == 4'd8 && nrd == 2, "R6", 72'(cap_len), 72'd8);
    chk(cap_bytes == exp, "R6", cap_bytes, exp);

    // R5 read with EEPROM off
    eeprom_mode = 2'b00;
    issue(8'h04, 8'h03, 1'b1, 4'd2, 64'd0);
    observe(20);
    chk(rearm_at >= 0 && nstart == 0 && nrd == 0, "R5", 72'(nrd), 72'd0);
    issue(8'h05, 8'h05, 1'b1, 4'd10, 64'h1122334455667788);
    observe(20);
    chk(rearm_at >= 0 && nstart == 0 && nwr == 0 && mem[26] == pat(26), "R5",
        72'(mem[26]), 72'(pat(26)));

    // R7 write block 5 then read back
    eeprom_mode = 2'b10;
    wpay = 64'h88_77_66_55_44_33_22_11;
    issue(8'h05, 8'h05, 1'b1, 4'd10, wpay);
    observe(20);
    chk(nstart == 1 && cap_len == 4'd1 && cap_bytes == 72'd0 && nwr == 2, "R7",
        {cap_len, cap_bytes[7:0]}, 72'h100);
    chk(mem[26] == 32'h44332211 && mem[27] == 32'h88776655, "R7",
        {mem[27], mem[26]}, 72'h88776655_44332211);
    issue(8'h04, 8'h05, 1'b1, 4'd2, 64'd0);
    observe(20);
    chk(cap_bytes == {8'h00, wpay}, "R7", cap_bytes, {8'h00, wpay});

    // R12 holdoff while busy
    tx_busy = 1'b1;
    issue(8'h08, 8'h00, 1'b1, 4'd1, 64'd0);
    observe(25);
    chk(nstart == 0 && rearm_at < 0, "R12", 72'(nstart), 72'd0);
    tx_busy = 1'b0;
    nstart = 0; rearm_at = -1; seen = 0;
    observe(10);
    chk(nstart == 1 && rearm_at == 1 && cap_len == 4'd1, "R12", 72'(rearm_at), 72'd1);

    // R3 single start: nothing further after rearm
    nstart = 0; rearm_at = -1; seen = 0;
    observe(8);
    chk(nstart == 0 && rearm_at < 0, "R3", 72'(nstart), 72'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule